// File: doc/BRIEF.md
# Burst SRAM Address Sequencer

This block produces the word address presented to a synchronous burst SRAM array. A start address is taken from the address bus when one of two active-low load strobes is asserted. One strobe belongs to a processor and the other to a memory controller. Further addresses in the burst are then made inside the block by a small counter, so a four-word burst needs only one external address.

The two low address bits walk through a group of four words and then wrap back to the start of the group. The upper bits keep the value that was loaded. A static mode input chooses between two orders. In linear order the low bits count upward from the loaded value. In interleaved order the low bits are the loaded value XORed with the count.

The address output is registered, and so is the chip-select state captured at the load. An active-low advance input steps the burst by one word per cycle, which gives the 3-1-1-1 access pattern: a first access followed by one new address on every cycle.

Top module: `burst_addr_seq`

## Requirements
- R1: After a synchronous reset, `addr_q` is 0 and `sel_q_n` is 1.
- R2: A clock edge with `padr_n`=0 and `ce_n`=0 loads the address. From the next cycle, `addr_q` equals the sampled `addr_in`, `sel_q_n` is 0, and the burst count restarts at 0.
- R3: A clock edge with `padr_n`=0 and `ce_n`=1 is ignored. `addr_q` and `sel_q_n` keep their values, and the count does not step even when `adv_n`=0.
- R4: A clock edge with `padr_n`=1 and `cadr_n`=0 always loads. `addr_q` takes `addr_in`, `sel_q_n` takes the sampled `ce_n` whatever its value, and the count restarts at 0.
- R5: When `padr_n` and `cadr_n` are both 0, the processor strobe has priority. With `ce_n`=1 nothing is loaded, and `addr_q` and `sel_q_n` stay unchanged.
- R6: With `lin_mode`=1 (linear order), the two low bits of `addr_q` equal (loaded low bits + count) mod 4.
- R7: With `lin_mode`=0 (interleaved order), the two low bits of `addr_q` equal the loaded low bits XOR count.
- R8: On an edge with both strobes at 1 and `adv_n`=0, the count steps by one, so consecutive advance cycles give a new address every cycle. With `adv_n`=1 and both strobes at 1, `addr_q` holds.
- R9: The count wraps modulo 4, so four advances return to the loaded address. Bits above the low two stay equal to the loaded value for the whole burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous reset, active high |
| addr_in | input | AW | External start address |
| ce_n | input | 1 | Chip enable, active low, sampled at loads |
| padr_n | input | 1 | Processor load strobe, active low, gated by `ce_n` |
| cadr_n | input | 1 | Controller load strobe, active low, not gated |
| adv_n | input | 1 | Burst advance, active low |
| lin_mode | input | 1 | Static order select: 1 linear, 0 interleaved |
| addr_q | output | AW | Registered word address |
| sel_q_n | output | 1 | Registered chip enable captured at the last load |

## Verification
The bench sweeps every starting low-bit value in both orders, loading through each strobe in turn and with two different upper-address patterns. For each case it checks five consecutive advances. This separates linear from interleaved sequencing, shows the modulo-4 wrap, and catches any disturbance of the upper bits. Stall cycles with `adv_n` high are placed between advances to confirm the address holds. Processor loads with the chip disabled, and both strobes together with the chip disabled, are applied while `adv_n` is low. These show the ignored load and the strobe priority. A controller load with the chip disabled confirms that this strobe always loads and that it carries the disabled chip-enable state through to `sel_q_n`.

// File: rtl/burst_seq_pkg.sv
package burst_seq_pkg;
  // Order in which the low address bits walk through a burst group.
  typedef enum logic {
    ORD_INTERLEAVE = 1'b0,
    ORD_LINEAR     = 1'b1
  } burst_order_e;
endpackage

// File: rtl/seq_load_arb.sv
module seq_load_arb (
  input  logic padr_n,
  input  logic cadr_n,
  input  logic ce_n,
  input  logic adv_n,
  output logic load,
  output logic step
);
  logic cpu_req;
  logic ctl_req;
  logic any_strb;

  always_comb begin
    cpu_req  = ~padr_n;
    // The controller strobe is considered only while the processor strobe is idle.
    ctl_req  = padr_n & ~cadr_n;
    any_strb = ~padr_n | ~cadr_n;
    load     = (cpu_req & ~ce_n) | ctl_req;
    // Any strobe cycle, whether taken or not, blocks the advance.
    step     = ~any_strb & ~adv_n;
  end
endmodule

// File: rtl/seq_burst_ctr.sv
module seq_burst_ctr #(
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          clr,
  input  logic          step,
  output logic [CW-1:0] cnt_nxt
);
  logic [CW-1:0] cnt_r;

  always_comb begin
    if (clr)       cnt_nxt = '0;
    else if (step) cnt_nxt = cnt_r + 1'b1;
    else           cnt_nxt = cnt_r;
  end

  always_ff @(posedge clk) begin
    if (rst) cnt_r <= '0;
    else     cnt_r <= cnt_nxt;
  end
endmodule

// File: rtl/seq_addr_map.sv
module seq_addr_map
  import burst_seq_pkg::*;
#(
  parameter int CW = 2
) (
  input  logic [CW-1:0] base_lo,
  input  logic [CW-1:0] cnt,
  input  burst_order_e  order,
  output logic [CW-1:0] lo
);
  always_comb begin
    if (order == ORD_LINEAR) lo = base_lo + cnt;
    else                     lo = base_lo ^ cnt;
  end
endmodule

// File: rtl/burst_addr_seq.sv
module burst_addr_seq
  import burst_seq_pkg::*;
#(
  parameter int AW = 20,
  parameter int CW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] addr_in,
  input  logic          ce_n,
  input  logic          padr_n,
  input  logic          cadr_n,
  input  logic          adv_n,
  input  logic          lin_mode,
  output logic [AW-1:0] addr_q,
  output logic          sel_q_n
);
  localparam int HW = AW - CW;

  logic          load;
  logic          step;
  logic [CW-1:0] cnt_nxt;
  logic [AW-1:0] base_r;
  logic [AW-1:0] base_nxt;
  logic [CW-1:0] lo_nxt;
  burst_order_e  order;

  seq_load_arb u_arb (
    .padr_n (padr_n),
    .cadr_n (cadr_n),
    .ce_n   (ce_n),
    .adv_n  (adv_n),
    .load   (load),
    .step   (step)
  );

  seq_burst_ctr #(.CW(CW)) u_ctr (
    .clk     (clk),
    .rst     (rst),
    .clr     (load),
    .step    (step),
    .cnt_nxt (cnt_nxt)
  );

  always_comb begin
    base_nxt = load ? addr_in : base_r;
    order    = lin_mode ? ORD_LINEAR : ORD_INTERLEAVE;
  end

  seq_addr_map #(.CW(CW)) u_map (
    .base_lo (base_nxt[CW-1:0]),
    .cnt     (cnt_nxt),
    .order   (order),
    .lo      (lo_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      base_r  <= '0;
      addr_q  <= '0;
      sel_q_n <= 1'b1;
    end else begin
      base_r <= base_nxt;
      addr_q <= {base_nxt[AW-1:CW], lo_nxt};
      if (load) sel_q_n <= ce_n;
    end
  end

  logic [HW-1:0] unused_hw;
  assign unused_hw = '0;
endmodule

// File: rtl/burst_addr_seq_chk.sv
module burst_addr_seq_chk #(
  parameter int AW = 20,
  parameter int CW = 2
) (
  input logic          clk,
  input logic          rst,
  input logic [AW-1:0] addr_in,
  input logic          ce_n,
  input logic          padr_n,
  input logic          cadr_n,
  input logic          adv_n,
  input logic          lin_mode,
  input logic [AW-1:0] addr_q,
  input logic          sel_q_n
);
  AST_RESET_STATE: assert property (@(posedge clk) rst |=> (addr_q == '0) && sel_q_n); // R1
  AST_CPU_LOAD: assert property (@(posedge clk) disable iff (rst)
    (!padr_n && !ce_n) |=> (addr_q == $past(addr_in)) && !sel_q_n); // R2
  AST_CPU_IGNORED: assert property (@(posedge clk) disable iff (rst)
    (!padr_n && ce_n) |=> $stable(addr_q) && $stable(sel_q_n)); // R3
  AST_CTL_LOAD: assert property (@(posedge clk) disable iff (rst)
    (padr_n && !cadr_n) |=> (addr_q == $past(addr_in)) && (sel_q_n == $past(ce_n))); // R4
  AST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (padr_n && cadr_n && adv_n) |=> $stable(addr_q)); // R8
  AST_UPPER_KEPT: assert property (@(posedge clk) disable iff (rst)
    (padr_n && cadr_n) |=> $stable(addr_q[AW-1:CW])); // R9
  AST_LINEAR_STEP: assert property (@(posedge clk) disable iff (rst)
    (padr_n && cadr_n && !adv_n && lin_mode && $stable(lin_mode))
    |=> (addr_q[CW-1:0] == CW'($past(addr_q[CW-1:0]) + 1'b1))); // R6
endmodule

bind burst_addr_seq burst_addr_seq_chk #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/burst_addr_seq_tb.sv
module burst_addr_seq_tb;
  localparam int AW = 20;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [AW-1:0] addr_in = '0;
  logic          ce_n = 1'b1;
  logic          padr_n = 1'b1;
  logic          cadr_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          lin_mode = 1'b1;
  logic [AW-1:0] addr_q;
  logic          sel_q_n;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  burst_addr_seq #(.AW(AW), .CW(2)) u_dut (
    .clk(clk), .rst(rst), .addr_in(addr_in), .ce_n(ce_n),
    .padr_n(padr_n), .cadr_n(cadr_n), .adv_n(adv_n),
    .lin_mode(lin_mode), .addr_q(addr_q), .sel_q_n(sel_q_n)
  );

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic chk(input string req, input logic [AW-1:0] exp_a, input logic exp_s);
    n_chk++;
    if (addr_q !== exp_a || sel_q_n !== exp_s) begin
      n_bad++;
      $display("FAIL %s: addr=%h sel_n=%b expected addr=%h sel_n=%b",
               req, addr_q, sel_q_n, exp_a, exp_s);
    end
  endtask

  function automatic logic [AW-1:0] expect_addr(input logic [AW-1:0] b, input int k, input bit lin);
    logic [1:0] lo;
    lo = lin ? 2'((b[1:0] + k) % 4) : (b[1:0] ^ 2'(k % 4));
    return {b[AW-1:2], lo};
  endfunction

  initial begin
    logic [AW-1:0] base;
    repeat (2) tick();
    chk("R1", '0, 1'b1);
    rst = 1'b0;

    for (int lin = 0; lin < 2; lin++)
      for (int up = 0; up < 2; up++)
        for (int src = 0; src < 2; src++)
          for (int b = 0; b < 4; b++) begin
            base = {(up != 0) ? 18'h2A5C3 : 18'h15A3C, 2'(b)};
            lin_mode = lin[0];
            addr_in = base; ce_n = 1'b0;
            if (src == 0) padr_n = 1'b0; else cadr_n = 1'b0;
            tick();
            padr_n = 1'b1; cadr_n = 1'b1; addr_in = ~base;
            chk(src == 0 ? "R2" : "R4", base, 1'b0);
            for (int k = 1; k <= 5; k++) begin
              adv_n = 1'b0;
              tick();
              chk(lin != 0 ? "R6_R9" : "R7_R9", expect_addr(base, k, lin != 0), 1'b0);
              if (k == 2) begin
                adv_n = 1'b1;
                tick();
                chk("R8", expect_addr(base, k, lin != 0), 1'b0);
              end
            end
            adv_n = 1'b1;
            // ignored processor load with chip disabled, advance requested
            padr_n = 1'b0; ce_n = 1'b1; adv_n = 1'b0;
            tick();
            chk("R3", expect_addr(base, 5, lin != 0), 1'b0);
            // both strobes, chip disabled: processor wins, nothing loaded
            cadr_n = 1'b0;
            tick();
            chk("R5", expect_addr(base, 5, lin != 0), 1'b0);
            padr_n = 1'b1; cadr_n = 1'b1; adv_n = 1'b1;
          end

    // controller load always takes effect, carrying the disabled enable
    addr_in = 20'hBEEF2; ce_n = 1'b1; cadr_n = 1'b0;
    tick();
    cadr_n = 1'b1;
    chk("R4", 20'hBEEF2, 1'b1);
    adv_n = 1'b0; lin_mode = 1'b1;
    tick();
    chk("R6", 20'hBEEF3, 1'b1);
    adv_n = 1'b1;
    rst = 1'b1;
    tick();
    chk("R1", '0, 1'b1);
    done = 1'b1;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog: run incomplete, expected completion");
    end
    done = 1'b1;
  end

  initial begin
    wait (done);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule